// File: doc/BRIEF.md
# Three-Wire Serial Register Access Master

This block sits on the host side of a three-wire register bus. The bus has a serial clock, an active-low frame enable and one bidirectional data line. A local agent hands over one request at a time through a valid/ready handshake. A request carries an 8-bit register address, a direction flag and a 16-bit write word. The block turns the request into a serial frame, runs the bus clock from a divided system clock and reports completion with a one-cycle pulse. For a read, that pulse comes with the 16-bit word returned by the slave.

Each frame starts with nine address-phase bits: the three upper address bits, then the direction flag, then the five lower address bits. A data phase of sixteen bits follows, most significant bit first. On a write, the master drives every bit and changes the data line only on falling clock edges, so the slave can sample on rising edges. On a read, the master releases the line on the falling edge after the last address bit. The slave then has half a clock period to turn the bus around. The master takes each returned bit just before a rising edge. The bidirectional line is modelled as three separate signals: output, output enable and input.

Top module: `twm_master`

## Requirements
- R1: In the address phase the first bits on the data line are A7, A6, A5, then the direction flag (1 = read, 0 = write), then A4 down to A0. Bit n of this sequence is valid from the falling clock edge after rise n (bit 0 from acceptance) through rise n+1.
- R2: On a write, bits 9 to 24 of the sequence are the write word, bit 15 first and bit 0 last, with the same edge timing as R1. A write frame has 25 rising clock edges.
- R3: The frame enable is low from the cycle after acceptance until the end of the frame and is high at all other times. The serial clock is low whenever the frame enable is high, and it changes only while the enable is low.
- R4: The data output never changes in a cycle where the serial clock rises. The first bit is driven one full half-period before the first rising edge.
- R5: On a read, output enable drops on the falling edge after rise 9 and stays low for the rest of the frame. The slave drives returned bit 15 from rise 10 through bit 0 from rise 25. The master samples just before rises 11 to 26, and a read frame has 26 rising edges. On the done pulse, rdata equals the returned word.
- R6: Every serial clock half-period lasts HALF system cycles. HALF is HALF_DIV, raised to ceil(MIN_HALF_NS / CLK_NS) when HALF_DIV is smaller (40 cycles at 5 ns and 200 ns).
- R7: reqReady is high only while idle, and a request is taken on a cycle with reqValid and reqReady both high. done is a single-cycle pulse in the cycle the frame enable returns high.
- R8: After reset, and after each frame ends, the frame enable stays high for two half-periods (one full serial clock period) before reqReady rises. A request held valid during this gap is taken on the first ready cycle.
- R9: After the final falling clock edge, the frame enable stays low for one more half-period (hold) before it rises.
- R10: During reset the frame enable is high, and the serial clock, output enable, reqReady and done are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Block idle and able to take a request |
| reqAddr | input | 8 | Register address |
| reqRw | input | 1 | Direction flag: 1 read, 0 write |
| reqWdata | input | 16 | Word to write |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Returned word, valid with done on a read |
| sclk | output | 1 | Serial bus clock |
| senN | output | 1 | Active-low frame enable |
| sdioOut | output | 1 | Data line value driven by the master |
| sdioOe | output | 1 | Master drives the data line when high |
| sdioIn | input | 1 | Data line value seen at the pad |

## Verification
Two situations are hard to reach from the ports. The first is the handover on a read, where the master's release of the line must land exactly between rise 9 and rise 10 while the slave's first bit appears only on rise 10. The bench's slave model keeps the input line high outside the slave's drive window, so a master that samples one edge early or late picks up ones and produces a different rdata on the all-zero read word. The second is the inter-frame gap. The stimulus raises reqValid again right after each done pulse, while the block is still in its gap, so a premature ready shows up as a mismatch against the reference model on that cycle. The bench also builds the block with HALF_DIV set below the minimum, so it checks that the half-period is raised to the limit.

// File: rtl/twm_pkg.sv
package twm_pkg;

  // Strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic load;      // take a new frame word
    logic shiftOut;  // advance the output shifter on a falling edge
    logic capture;   // take one returned bit before a rising edge
  } twStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_HOLD,
    ST_GAP
  } twState_t;

endpackage

// File: rtl/twm_ctrl.sv
module twm_ctrl
  import twm_pkg::*;
#(
  parameter int HALF   = 40,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqRw,
  output logic      reqReady,
  output logic      sclk,
  output logic      senN,
  output logic      sdoOe,
  output logic      done,
  output twStrobe_t strobe
);

  localparam int FRAME_BITS = ADDR_W + 1 + DATA_W;
  localparam int RISES_RD   = FRAME_BITS + 1;
  localparam int CNT_W      = $clog2(RISES_RD + 1);
  localparam int DIV_W      = $clog2(HALF + 1);
  localparam logic [CNT_W-1:0] LAST_WR  = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_RD  = CNT_W'(RISES_RD);
  localparam logic [CNT_W-1:0] TURN_AT  = CNT_W'(ADDR_W + 1);
  localparam logic [CNT_W-1:0] CAP_FROM = CNT_W'(ADDR_W + 2);
  localparam logic [DIV_W-1:0] DIV_END  = DIV_W'(HALF - 1);

  twState_t         state;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] bitCnt;
  logic             isRead;
  logic             gapHalf;
  logic             sclkQ;
  logic             senQ;
  logic             oeQ;
  logic             doneQ;
  logic             tick;
  logic [CNT_W-1:0] lastRise;

  assign tick     = (divCnt == DIV_END);
  assign lastRise = isRead ? LAST_RD : LAST_WR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_GAP;
      divCnt  <= '0;
      bitCnt  <= '0;
      isRead  <= 1'b0;
      gapHalf <= 1'b0;
      sclkQ   <= 1'b0;
      senQ    <= 1'b1;
      oeQ     <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (state == ST_IDLE) begin
        divCnt <= '0;
        if (reqValid) begin
          state  <= ST_SETUP;
          isRead <= reqRw;
          bitCnt <= '0;
          senQ   <= 1'b0;
          oeQ    <= 1'b1;
        end
      end else begin
        divCnt <= tick ? '0 : divCnt + DIV_W'(1);
        if (tick) begin
          unique case (state)
            ST_SETUP, ST_LOW: begin
              sclkQ  <= 1'b1;
              bitCnt <= bitCnt + CNT_W'(1);
              state  <= ST_HIGH;
            end
            ST_HIGH: begin
              sclkQ <= 1'b0;
              if (bitCnt == lastRise) state <= ST_HOLD;
              else                    state <= ST_LOW;
              if (isRead && bitCnt == TURN_AT) oeQ <= 1'b0;
            end
            ST_HOLD: begin
              senQ    <= 1'b1;
              oeQ     <= 1'b0;
              doneQ   <= 1'b1;
              gapHalf <= 1'b0;
              state   <= ST_GAP;
            end
            ST_GAP: begin
              if (gapHalf) state <= ST_IDLE;
              gapHalf <= 1'b1;
            end
            default: state <= ST_GAP;
          endcase
        end
      end
    end
  end

  always_comb begin
    strobe.load     = (state == ST_IDLE) && reqValid;
    strobe.shiftOut = (state == ST_HIGH) && tick && (bitCnt != lastRise);
    strobe.capture  = (state == ST_LOW) && tick && isRead && (bitCnt >= CAP_FROM);
  end

  assign reqReady = (state == ST_IDLE);
  assign sclk     = sclkQ;
  assign senN     = senQ;
  assign sdoOe    = oeQ;
  assign done     = doneQ;

  // Run-length tracker for the half-period check
  logic             prevSclk;
  logic [DIV_W:0]   runLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSclk <= 1'b0;
      runLen   <= '0;
    end else begin
      prevSclk <= sclkQ;
      if (sclkQ != prevSclk)             runLen <= (DIV_W+1)'(1);
      else if (runLen < (DIV_W+1)'(HALF)) runLen <= runLen + (DIV_W+1)'(1);
    end
  end

  // R3
  sclk_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sclkQ) || $fell(sclkQ)) |-> !senQ);

  // R3
  idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    senQ |-> !sclkQ);

  // R5
  oe_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    oeQ |-> !senQ);

  // R6
  half_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclkQ != prevSclk) |-> (runLen >= (DIV_W+1)'(HALF)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  // R7
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> (senQ && !sclkQ && !oeQ));

endmodule

// File: rtl/twm_dp.sv
module twm_dp
  import twm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int RW_POS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  twStrobe_t         strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqRw,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              sdi,
  output logic              sdo,
  output logic [DATA_W-1:0] rdata
);

  localparam int FRAME_BITS = ADDR_W + 1 + DATA_W;
  localparam int LOW_W      = ADDR_W - RW_POS;

  logic [FRAME_BITS-1:0] frameWord;
  logic [FRAME_BITS-1:0] outShift;
  logic [DATA_W-1:0]     inShift;

  assign frameWord = {reqAddr[ADDR_W-1 -: RW_POS], reqRw, reqAddr[LOW_W-1:0], reqWdata};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outShift <= '0;
      inShift  <= '0;
    end else begin
      if (strobe.load)
        outShift <= frameWord;
      else if (strobe.shiftOut)
        outShift <= {outShift[FRAME_BITS-2:0], 1'b0};
      if (strobe.capture)
        inShift <= {inShift[DATA_W-2:0], sdi};
    end
  end

  assign sdo   = outShift[FRAME_BITS-1];
  assign rdata = inShift;

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.load, strobe.shiftOut, strobe.capture}));

  // R5
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(inShift));

endmodule

// File: rtl/twm_master.sv
module twm_master
  import twm_pkg::*;
#(
  parameter int CLK_NS      = 5,
  parameter int MIN_HALF_NS = 200,
  parameter int HALF_DIV    = 40,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int RW_POS      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqRw,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              sclk,
  output logic              senN,
  output logic              sdioOut,
  output logic              sdioOe,
  input  logic              sdioIn
);

  localparam int MIN_DIV = (MIN_HALF_NS + CLK_NS - 1) / CLK_NS;
  localparam int HALF    = (HALF_DIV < MIN_DIV) ? MIN_DIV : HALF_DIV;

  twStrobe_t strobe;
  logic      sdo;

  twm_ctrl #(
    .HALF   (HALF),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqRw    (reqRw),
    .reqReady (reqReady),
    .sclk     (sclk),
    .senN     (senN),
    .sdoOe    (sdioOe),
    .done     (done),
    .strobe   (strobe)
  );

  twm_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .RW_POS (RW_POS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .reqRw    (reqRw),
    .reqWdata (reqWdata),
    .sdi      (sdioIn),
    .sdo      (sdo),
    .rdata    (rdata)
  );

  assign sdioOut = sdioOe ? sdo : 1'b0;

  // R4
  rise_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclk) |-> $stable(sdioOut));

  // R7
  accept_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (!senN && sdioOe));

endmodule

// File: tb/twm_master_tb.sv
`timescale 1ns/100ps
module twm_master_tb;

  localparam int H = 40;   // 200 ns / 5 ns, the clamped half-period

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic        reqReady;
  logic [7:0]  reqAddr;
  logic        reqRw;
  logic [15:0] reqWdata;
  logic        done;
  logic [15:0] rdata;
  logic        sclk;
  logic        senN;
  logic        sdioOut;
  logic        sdioOe;
  logic        sdioIn;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  logic [15:0] slaveWord;

  always #2.5 clk = ~clk;

  twm_master #(.HALF_DIV(10)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqRw(reqRw), .reqWdata(reqWdata),
    .done(done), .rdata(rdata), .sclk(sclk), .senN(senN),
    .sdioOut(sdioOut), .sdioOe(sdioOe), .sdioIn(sdioIn)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Reference model state
  bit          mBusy;
  int          mWait;
  int          mK;
  bit          mRw;
  logic [24:0] mFrame;
  logic [15:0] mWord;
  int          riseCnt;
  logic        obsSclk;
  logic        obsSdo;

  initial begin
    mBusy = 0; mWait = 2 * H; mK = 0; mRw = 0; mFrame = '0; mWord = '0;
    riseCnt = 0; obsSclk = 0; obsSdo = 0;
    forever begin
      @(negedge clk);
      #2;
      if (!rstN) begin
        mBusy = 0; mWait = 2 * H; riseCnt = 0; obsSclk = 0; obsSdo = 0;
      end else begin
        int  n;
        int  h;
        bit  eSen, eSclk, eOe, eDone, eReady;
        n = mRw ? 26 : 25;
        h = mK / H;
        if (mBusy) begin
          eSen   = !(mK < (2*n + 1) * H);
          eSclk  = (h >= 1) && (h <= 2*n - 1) && (h % 2 == 1);
          eOe    = (mK < (2*n + 1) * H) && !(mRw && h >= 18);
          eDone  = (mK == (2*n + 1) * H);
          eReady = 0;
        end else begin
          eSen = 1; eSclk = 0; eOe = 0; eDone = 0; eReady = (mWait == 0);
        end
        if (mBusy && h == 2*n)
          chk(senN == eSen, "R9", "hold senN", senN, eSen);
        else
          chk(senN == eSen, "R3", "senN", senN, eSen);
        chk(sclk == eSclk, "R6", "sclk", sclk, eSclk);
        chk(sdioOe == eOe, "R5", "sdioOe", sdioOe, eOe);
        chk(done == eDone, "R7", "done", done, eDone);
        chk(reqReady == eReady, "R8", "reqReady", reqReady, eReady);
        if (mBusy && eOe && h <= 2*n - 1) begin
          int idx;
          idx = h / 2;
          if (idx < 9)
            chk(sdioOut == mFrame[24-idx], "R1", "address bit", sdioOut, mFrame[24-idx]);
          else
            chk(sdioOut == mFrame[24-idx], "R2", "data bit", sdioOut, mFrame[24-idx]);
        end
        if (done && eDone && mRw)
          chk(rdata == mWord, "R5", "rdata", rdata, mWord);
        // slave model, reacts to rising serial clock edges
        if (sclk && !obsSclk) begin
          riseCnt++;
          chk(sdioOut == obsSdo, "R4", "sdio at rise", sdioOut, obsSdo);
          if (mBusy && mRw && riseCnt >= 10 && riseCnt <= 25)
            sdioIn = mWord[25 - riseCnt];
          else
            sdioIn = 1'b1;
        end
        obsSclk = sclk;
        obsSdo  = sdioOut;
        // advance model across the coming edge
        if (!mBusy) begin
          if (mWait > 0) mWait--;
          else if (reqValid) begin
            mBusy = 1; mK = 0; mRw = reqRw; riseCnt = 0;
            mFrame = {reqAddr[7:5], reqRw, reqAddr[4:0], reqWdata};
            mWord = slaveWord;
          end
        end else begin
          mK++;
          if (mK == (2*n + 3) * H) begin
            mBusy = 0; mWait = 0;
          end
        end
      end
    end
  end

  task automatic send(input logic [7:0] a, input logic rw,
                      input logic [15:0] wd, input logic [15:0] sw);
    @(negedge clk); #1;
    reqAddr = a; reqRw = rw; reqWdata = wd; slaveWord = sw; reqValid = 1'b1;
    while (!reqReady) begin
      @(negedge clk); #1;
    end
    @(negedge clk); #1;
    reqValid = 1'b0;
    do @(negedge clk); while (!done);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqAddr = '0; reqRw = 1'b0;
    reqWdata = '0; sdioIn = 1'b1; slaveWord = '0;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(senN == 1'b1, "R10", "reset senN", senN, 1);
    chk(sclk == 1'b0, "R10", "reset sclk", sclk, 0);
    chk(sdioOe == 1'b0, "R10", "reset sdioOe", sdioOe, 0);
    chk(reqReady == 1'b0, "R10", "reset reqReady", reqReady, 0);
    chk(done == 1'b0, "R10", "reset done", done, 0);
    #1 rstN = 1'b1;
    send(8'hA5, 1'b0, 16'h1234, 16'h0000);   // R1 R2 write
    send(8'h00, 1'b0, 16'hFFFF, 16'h0000);   // R2 all ones
    send(8'hFF, 1'b0, 16'h0000, 16'h0000);   // R1 all ones address
    send(8'h3C, 1'b1, 16'h0000, 16'hBEEF);   // R5 read
    send(8'h81, 1'b1, 16'hFFFF, 16'h8001);   // R5 end bits
    send(8'h5A, 1'b0, 16'hA55A, 16'h0000);   // R8 write after read gap
    send(8'h00, 1'b1, 16'h0000, 16'h0000);   // R5 zero word, turnaround edges
    send(8'hFF, 1'b1, 16'h0000, 16'hFFFF);   // R5 all ones
    repeat (400) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule